// File: doc/BRIEF.md
# PCI Power-Management Capability Registers

This block holds the power-management state of one PCI function. Configuration software reaches it through a simple port. The port takes a dword index, four byte enables, write data and a write strobe, and it returns read data without delay. Two 16-bit words sit in this window. One is a fixed capability word. The other is a control/status word that holds the power state, the wake enable and the wake status.

The function is either fully on (D0) or in the hot low-power state (D3hot). While it is in D3hot the block tells the rest of the function to stop decoding I/O and memory cycles and to hold back interrupts. Configuration access keeps working in that state. When software moves the function from D3hot back to D0, the block emits a one-cycle internal-reset pulse. Hardware reports wake events on an input. Software clears the resulting status by writing 1. The active-low wake output follows the status and the enable.

Two resets exist. A power-on reset clears everything. A bus reset returns the function to D0, and it keeps the wake enable and the wake status only when the enable was set.

Top module: `pm_cap_regs`

## Requirements
- R1: Dword index 1Ch reads 4003_0000h: the capability word 4003h in bits 31:16 and zero below. The capability word advertises wake from D3hot, D1 and D2 unsupported, no aux current, no device-specific init, no wake clock and version 011b. Writes to this index change nothing.
- R2: Dword index 1Dh reads the control/status word in bits 15:0: power state in 1:0, no-soft-reset in bit 3 (always 0), wake enable in bit 8 and wake status in bit 15. Every other bit reads 0. After power-on reset the word reads 0000h.
- R3: A write to index 1Dh with byte enable 0 set loads the power state from write data bits 1:0 when the value is 00 (D0) or 11 (D3hot). The values 01 and 10 are dropped and the previous state is kept.
- R4: In D3hot, io_block, mem_block and irq_block are all 1. In D0 they are all 0. The configuration registers stay readable and writable in D3hot.
- R5: int_rst is 1 for exactly one cycle, the first cycle in which the state reads D0 after having been D3hot. D0 to D0 and D0 to D3hot writes do not raise it.
- R6: wake_evt sets the wake status. A write with byte enable 1 and data bit 15 set clears it, and writing 0 there has no effect. A wake event in the same cycle as a clearing write leaves the status set.
- R7: pme_n is 0 exactly when the wake status and the wake enable are both 1.
- R8: A bus reset (rst_n low at a clock edge) sets the state to D0 without an int_rst pulse. It keeps the wake enable and the wake status if the enable was 1, and clears both otherwise.
- R9: Power-on reset (por_n low) clears the state, the enable, the status and int_rst.
- R10: Byte enables gate each byte: the state changes only with byte enable 0, and the enable and status change only with byte enable 1. Any other dword index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous bus reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr |
| wake_evt | input | 1 | Hardware wake event, sets the wake status |
| pme_n | output | 1 | Active-low wake request |
| io_block | output | 1 | Block I/O decode |
| mem_block | output | 1 | Block memory decode |
| irq_block | output | 1 | Block interrupts |
| int_rst | output | 1 | One-cycle internal reset on D3hot to D0 |

## Verification
The bench writes the reserved state codes 01 and 10. A design that accepted them would read back a state the function cannot hold. It walks D3hot to D0 and counts the int_rst cycles, which catches a pulse that is missing, lasts two cycles, or fires on D0 to D0 or D0 to D3hot. It sets a wake event and a clearing write in the same cycle. A design that gave the clear priority would lose a wake. It applies the bus reset with the enable both set and clear. A design that always kept or always dropped the wake context would then read back the wrong status and drive pme_n wrongly.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

    localparam int CFG_DW = 32;

    typedef enum logic [1:0] {
        PS_D0   = 2'b00,
        PS_D1   = 2'b01,
        PS_D2   = 2'b10,
        PS_D3H  = 2'b11
    } pstate_e;

    // power-state register and its reset pulse
    typedef struct packed {
        pstate_e ps;
        logic    int_rst;
    } pst_t;

    // wake context: enable and sticky status
    typedef struct packed {
        logic en;
        logic sts;
    } wake_t;

    // control/status bit positions decoded by software
    localparam int CSR_PS_LO  = 0;
    localparam int CSR_NSR    = 3;
    localparam int CSR_WEN    = 8;
    localparam int CSR_WSTS   = 15;

endpackage

// File: rtl/pm_cap_decode.sv
module pm_cap_decode #(
    parameter int          ADDR_W  = 6,
    parameter logic [5:0]  CAP_IDX = 6'h1C,
    parameter logic [5:0]  CSR_IDX = 6'h1D
) (
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_dw_addr,
    input  logic [3:0]        cfg_be,
    output logic              cap_sel,
    output logic              csr_sel,
    output logic              wr_lo,
    output logic              wr_hi
);

    localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_IDX);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_IDX);

    logic unused_be;

    always_comb begin
        cap_sel = (cfg_dw_addr == CAP_A);
        csr_sel = (cfg_dw_addr == CSR_A);
        wr_lo   = cfg_wr && csr_sel && cfg_be[0];
        wr_hi   = cfg_wr && csr_sel && cfg_be[1];
    end

    // upper bytes of the control/status dword are reserved
    assign unused_be = ^cfg_be[3:2];

endmodule

// File: rtl/pm_cap_pstate.sv
module pm_cap_pstate
    import pm_cap_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic [1:0] wr_ps,
    output pstate_e    ps,
    output logic       int_rst
);

    localparam pst_t PST_RST = '{ps: PS_D0, int_rst: 1'b0};

    pst_t pst_d, pst_q;
    logic ps_legal;

    always_comb begin
        pst_d         = pst_q;
        pst_d.int_rst = 1'b0;
        ps_legal      = (wr_ps == PS_D0) || (wr_ps == PS_D3H);
        if (wr_lo && ps_legal) begin
            pst_d.ps = pstate_e'(wr_ps);
        end
        if ((pst_q.ps == PS_D3H) && (pst_d.ps == PS_D0)) begin
            pst_d.int_rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pst_q <= PST_RST;
        end else if (!rst_n) begin
            pst_q <= PST_RST;
        end else begin
            pst_q <= pst_d;
        end
    end

    assign ps      = pst_q.ps;
    assign int_rst = pst_q.int_rst;

endmodule

// File: rtl/pm_cap_wake.sv
module pm_cap_wake
    import pm_cap_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wr_hi,
    input  logic wr_en_bit,
    input  logic wr_sts_bit,
    input  logic wake_evt,
    output logic wake_en,
    output logic wake_sts,
    output logic pme_n
);

    wake_t wk_d, wk_q, wk_keep;

    always_comb begin
        wk_d = wk_q;
        if (wr_hi) begin
            wk_d.en = wr_en_bit;
            if (wr_sts_bit) begin
                wk_d.sts = 1'b0;
            end
        end
        // a new event beats a clearing write
        if (wake_evt) begin
            wk_d.sts = 1'b1;
        end
        // bus reset keeps the context only when enabled
        wk_keep = wk_q.en ? wk_q : '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wk_q <= '0;
        end else if (!rst_n) begin
            wk_q <= wk_keep;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign wake_en  = wk_q.en;
    assign wake_sts = wk_q.sts;
    assign pme_n    = ~(wk_q.en & wk_q.sts);

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
    import pm_cap_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [5:0]  CAP_IDX  = 6'h1C,
    parameter logic [5:0]  CSR_IDX  = 6'h1D,
    parameter logic [15:0] CAP_WORD = 16'h4003
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_dw_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              wake_evt,
    output logic              pme_n,
    output logic              io_block,
    output logic              mem_block,
    output logic              irq_block,
    output logic              int_rst
);

    logic    cap_sel, csr_sel, wr_lo, wr_hi;
    pstate_e ps_cur;
    logic    wake_en, wake_sts;
    logic    in_d3;
    logic [15:0] csr_word;
    logic    unused_wdata;

    pm_cap_decode #(
        .ADDR_W  (ADDR_W),
        .CAP_IDX (CAP_IDX),
        .CSR_IDX (CSR_IDX)
    ) u_decode (
        .cfg_wr      (cfg_wr),
        .cfg_dw_addr (cfg_dw_addr),
        .cfg_be      (cfg_be),
        .cap_sel     (cap_sel),
        .csr_sel     (csr_sel),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi)
    );

    pm_cap_pstate u_pstate (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_ps   (cfg_wdata[CSR_PS_LO +: 2]),
        .ps      (ps_cur),
        .int_rst (int_rst)
    );

    pm_cap_wake u_wake (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .wr_hi      (wr_hi),
        .wr_en_bit  (cfg_wdata[CSR_WEN]),
        .wr_sts_bit (cfg_wdata[CSR_WSTS]),
        .wake_evt   (wake_evt),
        .wake_en    (wake_en),
        .wake_sts   (wake_sts),
        .pme_n      (pme_n)
    );

    always_comb begin
        in_d3     = (ps_cur == PS_D3H);
        io_block  = in_d3;
        mem_block = in_d3;
        irq_block = in_d3;
    end

    always_comb begin
        csr_word                    = '0;
        csr_word[CSR_PS_LO +: 2]    = ps_cur;
        csr_word[CSR_NSR]           = 1'b0;
        csr_word[CSR_WEN]           = wake_en;
        csr_word[CSR_WSTS]          = wake_sts;
        cfg_rdata                   = '0;
        if (cap_sel) begin
            cfg_rdata = {CAP_WORD, 16'h0000};
        end else if (csr_sel) begin
            cfg_rdata = {16'h0000, csr_word};
        end
    end

    assign unused_wdata = ^{cfg_wdata[31:16], cfg_wdata[14:9], cfg_wdata[7:2]};

endmodule

module pm_cap_regs_chk
    import pm_cap_pkg::*;
(
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic [1:0] wr_ps,
    input logic       wr_sts_bit,
    input logic       wake_evt,
    input pstate_e    ps_cur,
    input logic       wake_en,
    input logic       wake_sts,
    input logic       int_rst,
    input logic       io_block
);

    // R3
    ps_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && wr_lo && (wr_ps == 2'b01 || wr_ps == 2'b10)) |=> $stable(ps_cur));

    // R5
    rst_width_chk: assert property (@(posedge clk) disable iff (!por_n)
        int_rst |=> !int_rst);

    // R5
    rst_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && ps_cur == PS_D3H && wr_lo && wr_ps == 2'b00) |=> int_rst);

    // R6
    wake_win_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && wake_evt) |=> wake_sts);

    // R6
    clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && wr_hi && wr_sts_bit && !wake_evt) |=> !wake_sts);

    // R8
    bus_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (ps_cur == PS_D0 && !int_rst && !io_block));

    // R8
    keep_ctx_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && wake_en) |=> (wake_en && wake_sts == $past(wake_sts)));

endmodule

bind pm_cap_regs pm_cap_regs_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wr_ps      (cfg_wdata[1:0]),
    .wr_sts_bit (cfg_wdata[15]),
    .wake_evt   (wake_evt),
    .ps_cur     (ps_cur),
    .wake_en    (wake_en),
    .wake_sts   (wake_sts),
    .int_rst    (int_rst),
    .io_block   (io_block)
);

// File: tb/pm_cap_regs_bench.sv
module pm_cap_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] CAP = 6'h1C;
    localparam logic [5:0] CSR = 6'h1D;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = CSR;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wake_evt = 1'b0;
    logic        pme_n, io_block, mem_block, irq_block, int_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_cap_regs u_pm_cap_regs (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_evt(wake_evt), .pme_n(pme_n),
        .io_block(io_block), .mem_block(mem_block), .irq_block(irq_block),
        .int_rst(int_rst)
    );

    // vector: be[51:48], wdata[47:16], expected CSR low word [15:0]
    localparam int NV = 8;
    localparam logic [51:0] VEC [NV] = '{
        {4'h1, 32'h0000_0003, 16'h0003},   // R3 enter D3hot
        {4'h1, 32'h0000_0001, 16'h0003},   // R3 01 dropped
        {4'h1, 32'h0000_0002, 16'h0003},   // R3 10 dropped
        {4'h2, 32'h0000_0100, 16'h0103},   // R10 enable via byte 1 only
        {4'h1, 32'h0000_0000, 16'h0100},   // R3 back to D0
        {4'hF, 32'hFFFF_FFFF, 16'h0103},   // R2 reserved bits stay 0
        {4'h0, 32'h0000_0000, 16'h0103},   // R10 no enables, no change
        {4'h3, 32'h0000_0000, 16'h0000}    // R3 D0, enable off
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be,
                             input logic [31:0] d, input logic wk);
        @(negedge clk);
        cfg_dw_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1; wake_evt = wk;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; wake_evt = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_dw_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wake_pulse();
        @(negedge clk);
        wake_evt = 1'b1;
        @(posedge clk);
        #1;
        wake_evt = 1'b0;
    endtask

    task automatic bus_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic        pulse_cnt;
        #(CLK_PERIOD * 2 + 3);
        por_n = 1'b1;
        @(posedge clk); #1;

        // reset state
        rd(CSR, r); chk("R2 reset csr", r, 32'h0);
        rd(CAP, r); chk("R1 cap word", r, 32'h4003_0000);
        chk("R9 reset outputs", {31'd0, pme_n}, 32'd1);
        chk("R4 reset blocks", {29'd0, io_block, mem_block, irq_block}, 32'd0);
        chk("R5 reset int_rst", {31'd0, int_rst}, 32'd0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            cfg_write(CSR, VEC[i][51:48], VEC[i][47:16], 1'b0);
            rd(CSR, r);
            chk("R3/R10 vector", r, {16'h0, VEC[i][15:0]});
        end

        // R1 write to capability ignored
        cfg_write(CAP, 4'hF, 32'h0000_FFFF, 1'b0);
        rd(CAP, r); chk("R1 cap write ignored", r, 32'h4003_0000);
        // R10 other index
        cfg_write(6'h1E, 4'hF, 32'hFFFF_FFFF, 1'b0);
        rd(6'h1E, r); chk("R10 other index reads 0", r, 32'h0);
        rd(CSR, r); chk("R10 other index no effect", r, 32'h0);

        // R4 and R5: D0->D3 gives no pulse, D3->D0 one pulse
        cfg_write(CSR, 4'h1, 32'h3, 1'b0);
        chk("R5 no pulse entering D3hot", {31'd0, int_rst}, 32'd0);
        chk("R4 blocks in D3hot", {29'd0, io_block, mem_block, irq_block}, 32'd7);
        cfg_write(CSR, 4'h2, 32'h0100, 1'b0);
        rd(CSR, r); chk("R4 config writable in D3hot", r, 32'h0103);
        cfg_write(CSR, 4'h1, 32'h0, 1'b0);
        chk("R5 pulse on D3hot to D0", {31'd0, int_rst}, 32'd1);
        chk("R4 blocks released", {29'd0, io_block, mem_block, irq_block}, 32'd0);
        @(posedge clk); #1;
        pulse_cnt = int_rst;
        chk("R5 pulse one cycle", {31'd0, pulse_cnt}, 32'd0);
        cfg_write(CSR, 4'h1, 32'h0, 1'b0);
        chk("R5 no pulse D0 to D0", {31'd0, int_rst}, 32'd0);

        // R6 / R7 wake status and PME#
        cfg_write(CSR, 4'h2, 32'h0, 1'b0);
        wake_pulse();
        rd(CSR, r); chk("R6 wake sets status", r, 32'h8000);
        chk("R7 pme_n high without enable", {31'd0, pme_n}, 32'd1);
        cfg_write(CSR, 4'h2, 32'h0100, 1'b0);
        chk("R7 pme_n low with both", {31'd0, pme_n}, 32'd0);
        cfg_write(CSR, 4'h2, 32'h0100, 1'b0);
        rd(CSR, r); chk("R6 write 0 keeps status", r, 32'h8100);
        cfg_write(CSR, 4'h2, 32'h8100, 1'b1);
        rd(CSR, r); chk("R6 set beats clear", r, 32'h8100);
        cfg_write(CSR, 4'h2, 32'h8100, 1'b0);
        rd(CSR, r); chk("R6 write 1 clears", r, 32'h0100);
        chk("R7 pme_n released", {31'd0, pme_n}, 32'd1);

        // R8 bus reset with enable set keeps context
        wake_pulse();
        cfg_write(CSR, 4'h1, 32'h3, 1'b0);
        bus_reset();
        rd(CSR, r); chk("R8 keep context when enabled", r, 32'h8100);
        chk("R8 no pulse on bus reset", {31'd0, int_rst}, 32'd0);
        chk("R8 blocks cleared", {29'd0, io_block, mem_block, irq_block}, 32'd0);
        // R8 bus reset with enable clear drops status
        cfg_write(CSR, 4'h2, 32'h0000, 1'b0);
        rd(CSR, r); chk("R8 prep status only", r, 32'h8000);
        bus_reset();
        rd(CSR, r); chk("R8 drop context when disabled", r, 32'h0);

        // R9 power-on reset clears all
        wake_pulse();
        cfg_write(CSR, 4'h3, 32'h0103, 1'b0);
        @(negedge clk);
        por_n = 1'b0;
        #2;
        por_n = 1'b1;
        @(posedge clk); #1;
        rd(CSR, r); chk("R9 por clears", r, 32'h0);
        chk("R9 pme_n after por", {31'd0, pme_n}, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule